// File: doc/BRIEF.md
# Packed Halfword Add/Subtract Unit

This execute-stage datapath treats each of its two 32-bit source words as two signed 16-bit lanes: the low half sits in bits 15:0 and the high half in bits 31:16. A 2-bit operation code selects one of four arithmetic modes:

- a plain lane-wise add;
- a plain lane-wise subtract;
- two exchange modes, in which the low lane of the first operand is combined with the high lane of the second, and the high lane of the first with the low lane of the second.

Each lane is computed at 17 bits, so the sign of the true result is available. That sign drives a 4-bit greater-or-equal (GE) vector, which has two identical bits per lane.

The unit registers its outputs, so results appear one clock after issue. An instruction issues with a 4-bit condition field. The value 0xE means unconditional. Any other value relies on a condition-pass input that the surrounding pipeline evaluates. A suppressed instruction raises no strobe, and both the result and the GE register keep their previous values.

Top module: `packed_hadd_unit`

## Requirements
- R1: With operation code 0, result low lane = n_lo + m_lo and result high lane = n_hi + m_hi.
- R2: With operation code 1, result low lane = n_lo - m_hi and result high lane = n_hi + m_lo.
- R3: With operation code 2, result low lane = n_lo + m_hi and result high lane = n_hi - m_lo.
- R4: With operation code 3, result low lane = n_lo - m_lo and result high lane = n_hi - m_hi.
- R5: Bits 15:0 of the result hold the low 16 bits of the low-lane sum. Bits 31:16 hold the low 16 bits of the high-lane sum. Wrap-around is not saturated.
- R6: GE bits 1:0 are both 1 when the 17-bit signed low-lane result is zero or positive, and both 0 otherwise.
- R7: GE bits 3:2 are both 1 when the 17-bit signed high-lane result is zero or positive, and both 0 otherwise.
- R8: An issued instruction executes when its condition field is 0xE, whatever the value of cond_pass_i. For any other field value, it executes only when cond_pass_i is 1.
- R9: The cycle after an issue that does not execute, or after a cycle with no issue, result_vld_o and ge_upd_o are 0, and result_o and ge_o are unchanged.
- R10: An executed instruction updates result_o and ge_o, and raises result_vld_o and ge_upd_o, on the first rising clock edge after issue. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction is presented this cycle |
| op_i | input | 2 | Operation code (0 add, 1 add/sub exchange, 2 sub/add exchange, 3 subtract) |
| cond_i | input | 4 | Condition field; 0xE is unconditional |
| cond_pass_i | input | 1 | External condition evaluation result |
| opn_n_i | input | 32 | First operand (n lanes) |
| opn_m_i | input | 32 | Second operand (m lanes) |
| result_o | output | 32 | Packed lane results |
| result_vld_o | output | 1 | Result written this cycle |
| ge_o | output | 4 | Greater-or-equal flags, two per lane |
| ge_upd_o | output | 1 | GE flags updated this cycle |

## Verification
The four operation codes are driven with words of mixed-sign values. This distinguishes the straight modes from the exchange modes, because only a correct lane pairing yields the expected halves. Lane values of 0x7FFF, 0x8000, 0xFFFF and 0x0000 push sums past the 16-bit range: a GE flag taken from the wrapped 16-bit value disagrees with the 17-bit sign there, and an exact zero result shows that the flags treat zero as non-negative. Condition fields of 0xE and of other values, each with the pass input both high and low, separate gating on the field from gating on the input, and the held outputs show that a suppressed instruction leaves no trace.

// File: rtl/phu_pkg.sv
package phu_pkg;
    typedef enum logic [1:0] {
        OP_ADD2 = 2'd0,
        OP_ASX  = 2'd1,
        OP_SAX  = 2'd2,
        OP_SUB2 = 2'd3
    } phu_op_e;

    localparam logic [3:0] COND_ALWAYS = 4'hE;
    localparam int unsigned NUM_LANES  = 2;
    localparam int unsigned GE_PER_LANE = 2;
endpackage

// File: rtl/phu_route.sv
module phu_route
    import phu_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned DATA_W = NUM_LANES * LANE_W
) (
    input  logic [1:0]                      op_i,
    input  logic [DATA_W-1:0]               n_i,
    input  logic [DATA_W-1:0]               m_i,
    output logic [NUM_LANES-1:0][LANE_W-1:0] x_o,
    output logic [NUM_LANES-1:0][LANE_W-1:0] y_o,
    output logic [NUM_LANES-1:0]            sub_o
);
    logic [LANE_W-1:0] n_lo, n_hi, m_lo, m_hi;
    phu_op_e op;

    always_comb begin
        op   = phu_op_e'(op_i);
        n_lo = n_i[LANE_W-1:0];
        n_hi = n_i[DATA_W-1:LANE_W];
        m_lo = m_i[LANE_W-1:0];
        m_hi = m_i[DATA_W-1:LANE_W];
        x_o[0] = n_lo;
        x_o[1] = n_hi;
        unique case (op)
            OP_ADD2: begin y_o[0] = m_lo; y_o[1] = m_hi; sub_o = 2'b00; end
            OP_ASX:  begin y_o[0] = m_hi; y_o[1] = m_lo; sub_o = 2'b01; end
            OP_SAX:  begin y_o[0] = m_hi; y_o[1] = m_lo; sub_o = 2'b10; end
            OP_SUB2: begin y_o[0] = m_lo; y_o[1] = m_hi; sub_o = 2'b11; end
            default: begin y_o[0] = m_lo; y_o[1] = m_hi; sub_o = 2'b00; end
        endcase
    end
endmodule

// File: rtl/phu_lane.sv
module phu_lane #(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned SUM_W = LANE_W + 1
) (
    input  logic [LANE_W-1:0] x_i,
    input  logic [LANE_W-1:0] y_i,
    input  logic              sub_i,
    output logic [SUM_W-1:0]  sum_o,
    output logic              nonneg_o
);
    logic signed [SUM_W-1:0] xe, ye;

    always_comb begin
        xe       = $signed({x_i[LANE_W-1], x_i});
        ye       = $signed({y_i[LANE_W-1], y_i});
        sum_o    = sub_i ? (xe - ye) : (xe + ye);
        nonneg_o = ~sum_o[SUM_W-1];
    end
endmodule

// File: rtl/packed_hadd_unit.sv
module packed_hadd_unit
    import phu_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned DATA_W = NUM_LANES * LANE_W,
    localparam int unsigned SUM_W  = LANE_W + 1,
    localparam int unsigned GE_W   = NUM_LANES * GE_PER_LANE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [1:0]        op_i,
    input  logic [3:0]        cond_i,
    input  logic              cond_pass_i,
    input  logic [DATA_W-1:0] opn_n_i,
    input  logic [DATA_W-1:0] opn_m_i,
    output logic [DATA_W-1:0] result_o,
    output logic              result_vld_o,
    output logic [GE_W-1:0]   ge_o,
    output logic              ge_upd_o
);
    logic [NUM_LANES-1:0][LANE_W-1:0] lx, ly;
    logic [NUM_LANES-1:0]             lsub, lnonneg;
    logic [NUM_LANES-1:0][SUM_W-1:0]  lsum;
    logic [DATA_W-1:0]                res_next;
    logic [GE_W-1:0]                  ge_next;
    logic                             exec;

    phu_route #(.LANE_W(LANE_W)) route_i (
        .op_i (op_i),
        .n_i  (opn_n_i),
        .m_i  (opn_m_i),
        .x_o  (lx),
        .y_o  (ly),
        .sub_o(lsub)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        phu_lane #(.LANE_W(LANE_W)) lane_i (
            .x_i     (lx[g]),
            .y_i     (ly[g]),
            .sub_i   (lsub[g]),
            .sum_o   (lsum[g]),
            .nonneg_o(lnonneg[g])
        );
        assign res_next[g*LANE_W +: LANE_W]          = lsum[g][LANE_W-1:0];
        assign ge_next[g*GE_PER_LANE +: GE_PER_LANE] = {GE_PER_LANE{lnonneg[g]}};
    end

    assign exec = issue_i && ((cond_i == COND_ALWAYS) || cond_pass_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vld_o <= 1'b0;
            ge_upd_o     <= 1'b0;
        end else begin
            result_vld_o <= exec;
            ge_upd_o     <= exec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            ge_o     <= '0;
        end else if (exec) begin
            result_o <= res_next;
            ge_o     <= ge_next;
        end
    end
endmodule

// File: rtl/packed_hadd_chk.sv
module packed_hadd_chk #(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned DATA_W = 2 * LANE_W,
    localparam int unsigned SUM_W  = LANE_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              issue_i,
    input logic [1:0]        op_i,
    input logic [3:0]        cond_i,
    input logic              cond_pass_i,
    input logic [DATA_W-1:0] opn_n_i,
    input logic [DATA_W-1:0] opn_m_i,
    input logic [DATA_W-1:0] result_o,
    input logic              result_vld_o,
    input logic [3:0]        ge_o,
    input logic              ge_upd_o
);
    logic             go;
    logic [LANE_W-1:0] add_lo, sub_hi;
    logic [SUM_W-1:0]  add_lo_w;

    assign go       = issue_i && (cond_i == 4'hE || cond_pass_i);
    assign add_lo   = opn_n_i[LANE_W-1:0] + opn_m_i[LANE_W-1:0];
    assign sub_hi   = opn_n_i[DATA_W-1:LANE_W] - opn_m_i[DATA_W-1:LANE_W];
    assign add_lo_w = {opn_n_i[LANE_W-1], opn_n_i[LANE_W-1:0]}
                    + {opn_m_i[LANE_W-1], opn_m_i[LANE_W-1:0]};

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> (!result_vld_o && !ge_upd_o && $stable(result_o) && $stable(ge_o)));

    // R8
    uncond_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && cond_i == 4'hE) |=> (result_vld_o && ge_upd_o));

    // R8
    cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && cond_i != 4'hE && !cond_pass_i) |=> !result_vld_o);

    // R1
    add_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_i == 2'd0) |=> (result_o[LANE_W-1:0] == $past(add_lo)));

    // R4
    sub_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_i == 2'd3) |=> (result_o[DATA_W-1:LANE_W] == $past(sub_hi)));

    // R6
    ge_low_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op_i == 2'd0) |=> (ge_o[1:0] == {2{~$past(add_lo_w[SUM_W-1])}}));
endmodule

bind packed_hadd_unit packed_hadd_chk #(.LANE_W(LANE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .op_i        (op_i),
    .cond_i      (cond_i),
    .cond_pass_i (cond_pass_i),
    .opn_n_i     (opn_n_i),
    .opn_m_i     (opn_m_i),
    .result_o    (result_o),
    .result_vld_o(result_vld_o),
    .ge_o        (ge_o),
    .ge_upd_o    (ge_upd_o)
);

// File: tb/packed_hadd_unit_tb_top.sv
`timescale 1ns/1ps
module packed_hadd_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [3:0]  cond_i = 4'hE;
    logic        cond_pass_i = 1'b0;
    logic [31:0] opn_n_i = '0;
    logic [31:0] opn_m_i = '0;
    logic [31:0] result_o;
    logic        result_vld_o;
    logic [3:0]  ge_o;
    logic        ge_upd_o;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    packed_hadd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
        .cond_i(cond_i), .cond_pass_i(cond_pass_i),
        .opn_n_i(opn_n_i), .opn_m_i(opn_m_i),
        .result_o(result_o), .result_vld_o(result_vld_o),
        .ge_o(ge_o), .ge_upd_o(ge_upd_o)
    );

    // {op, n, m}
    localparam logic [65:0] VEC [14] = '{
        {2'd0, 32'h1234_5678, 32'h0101_0202},
        {2'd0, 32'h7FFF_8000, 32'h0001_FFFF},
        {2'd0, 32'hFFFF_0000, 32'hFFFF_0000},
        {2'd1, 32'h0010_0020, 32'h0003_0005},
        {2'd1, 32'h8000_7FFF, 32'h8000_FFFF},
        {2'd1, 32'h0000_0000, 32'h0001_0000},
        {2'd2, 32'h0010_0020, 32'h0003_0005},
        {2'd2, 32'h8000_7FFF, 32'h0001_7FFF},
        {2'd2, 32'hFFFF_FFFF, 32'hFFFF_0001},
        {2'd3, 32'h0000_0000, 32'h0000_0000},
        {2'd3, 32'h8000_7FFF, 32'h0001_FFFF},
        {2'd3, 32'h7FFF_8000, 32'hFFFF_0001},
        {2'd0, 32'hA5A5_5A5A, 32'h3C3C_C3C3},
        {2'd3, 32'hC001_0FF0, 32'h4002_F00F}
    };

    function automatic logic [16:0] sx(input logic [15:0] v);
        return {v[15], v};
    endfunction

    function automatic logic [35:0] model(input logic [1:0] op,
                                          input logic [31:0] n,
                                          input logic [31:0] m);
        logic [16:0] lo, hi;
        case (op)
            2'd0: begin lo = sx(n[15:0]) + sx(m[15:0]);  hi = sx(n[31:16]) + sx(m[31:16]); end
            2'd1: begin lo = sx(n[15:0]) - sx(m[31:16]); hi = sx(n[31:16]) + sx(m[15:0]);  end
            2'd2: begin lo = sx(n[15:0]) + sx(m[31:16]); hi = sx(n[31:16]) - sx(m[15:0]);  end
            default: begin lo = sx(n[15:0]) - sx(m[15:0]); hi = sx(n[31:16]) - sx(m[31:16]); end
        endcase
        return {{2{~hi[16]}}, {2{~lo[16]}}, hi[15:0], lo[15:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input logic [3:0] cond, input logic pass,
                         input logic [31:0] n, input logic [31:0] m);
        @(negedge clk);
        issue_i = 1'b1; op_i = op; cond_i = cond; cond_pass_i = pass;
        opn_n_i = n; opn_m_i = m;
        @(posedge clk);
        #1;
        issue_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] held_r;
        logic [3:0]  held_g;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10 reset result", result_o, 32'h0);
        check("R10 reset flags", {26'd0, ge_upd_o, result_vld_o, ge_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6 R7 table walk
        for (int i = 0; i < 14; i++) begin
            logic [35:0] e;
            e = model(VEC[i][65:64], VEC[i][63:32], VEC[i][31:0]);
            issue(VEC[i][65:64], 4'hE, 1'b0, VEC[i][63:32], VEC[i][31:0]);
            check($sformatf("R1-op%0d R5 result vec%0d", VEC[i][65:64], i), result_o, e[31:0]);
            check($sformatf("R6 R7 ge vec%0d", i), {28'd0, ge_o}, {28'd0, e[35:32]});
            check("R10 strobes", {30'd0, result_vld_o, ge_upd_o}, 32'h3);
        end

        // R1 R5 R6 R7: 17-bit sign versus wrapped value
        issue(2'd0, 4'hE, 1'b0, 32'h7FFF_8000, 32'h0001_FFFF);
        check("R1 R5 overflow pack", result_o, 32'h8000_7FFF);
        check("R6 R7 overflow ge", {28'd0, ge_o}, 32'hC);
        // R2 exchange pairing
        issue(2'd1, 4'hE, 1'b0, 32'h0000_0000, 32'h0001_0000);
        check("R2 exchange", result_o, 32'h0000_FFFF);
        check("R6 R2 ge", {28'd0, ge_o}, 32'hC);
        // R3 exchange pairing, zero is non-negative
        issue(2'd2, 4'hE, 1'b0, 32'h0000_0000, 32'h0001_0000);
        check("R3 exchange", result_o, 32'h0000_0001);
        check("R7 zero ge", {28'd0, ge_o}, 32'hF);
        // R4 subtract to zero
        issue(2'd3, 4'hE, 1'b0, 32'h1234_8765, 32'h1234_8765);
        check("R4 subtract zero", result_o, 32'h0);
        check("R6 R7 zero ge", {28'd0, ge_o}, 32'hF);

        // R8 conditional pass executes
        issue(2'd3, 4'h0, 1'b1, 32'h0000_0000, 32'h0001_0001);
        check("R8 pass executes", result_o, 32'hFFFF_FFFF);
        check("R8 pass strobe", {31'd0, result_vld_o}, 32'h1);
        held_r = result_o;
        held_g = ge_o;

        // R8 R9 condition fails: nothing changes
        issue(2'd0, 4'h1, 1'b0, 32'h0005_0005, 32'h0005_0005);
        check("R8 fail no strobe", {30'd0, result_vld_o, ge_upd_o}, 32'h0);
        check("R9 result held", result_o, held_r);
        check("R9 ge held", {28'd0, ge_o}, {28'd0, held_g});

        // R9 idle cycle
        @(posedge clk);
        #1;
        check("R9 idle strobes", {30'd0, result_vld_o, ge_upd_o}, 32'h0);
        check("R9 idle held", result_o, held_r);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule